// File: doc/BRIEF.md
# Floating-Point Control and Status Word Unit

This unit keeps the 32-bit control and status word of a floating-point coprocessor, together with a revision register that always reads as zero. Software reaches it through move-to and move-from control-register commands that carry a 5-bit register index. The arithmetic datapath reports a 5-bit exception vector for each operation it finishes. A separate compare unit sets or clears single condition-code bits.

The unit drives several fields of the word straight to the datapath: the rounding mode, the flush-denormal control and the eight condition codes. It also produces two trap signals. One is a same-cycle signal that stops the finishing operation from writing its result. The other is a level request that stays high while an enabled exception is pending in the stored word.

Word layout:
- Rounding mode: bits 1:0.
- Sticky flags: bits 6:2.
- Enables: bits 11:7.
- Cause: bits 17:12.
- Condition code 0: bit 23.
- Flush-denormal control: bit 24.
- Condition codes 1 to 7: bits 25 to 31.

Inside each 5-bit exception field the order from the lowest bit up is inexact, underflow, overflow, divide-by-zero, invalid. The unit has no state machine. It is one register with a combinational next-word chain in front of it: software load, then exception merge, then condition-code merge.

Top module: `fcsr_unit`

## Requirements
- R1: A synchronous active-low reset clears the whole status word to zero. All exported fields and both trap outputs then read zero.
- R2: A read with index 31 returns the stored status word. A read with any other index, including the revision index 0, returns zero.
- R3: Only a write with index 31 changes the word. A write with any other index leaves it unchanged.
- R4: `round_mode` equals word bits 1:0, coded 0 = nearest, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. `flush_denorm` equals word bit 24.
- R5: An accepted operation replaces the cause field (bits 17:12) with `{1'b0, op_cause}`, where `op_cause` bit 0 = inexact, 1 = underflow, 2 = overflow, 3 = divide-by-zero, 4 = invalid. The same vector is ORed into the flag field (bits 6:2), and set flags stay set until software writes the word.
- R6: `wb_block` is high in the same cycle as `op_valid` when `op_cause` AND the enable field (bits 11:7) as stored before the operation is nonzero. It is never high without `op_valid`.
- R7: `trap_req` is high exactly when stored cause bits 16:12 AND stored enable bits 11:7 is nonzero. The enable bit at position k lines up with the cause bit at position k+5.
- R8: A software write to index 31 whose value has an enabled cause pending raises `trap_req` from the next cycle, with no operation needed.
- R9: A compare with selector n writes `cmp_result` into condition code n: bit 23 for n = 0, bit 24+n otherwise. The other codes are unchanged. `cond_codes[n]` outputs code n.
- R10: A write to index 31 in the same cycle as an operation or a compare wins for the whole word. An operation and a compare in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_idx | input | 5 | Control-register read index |
| rd_data | output | 32 | Read data (combinational) |
| wr_en | input | 1 | Move-to-control-register strobe |
| wr_idx | input | 5 | Write index |
| wr_data | input | 32 | Write value |
| op_valid | input | 1 | An arithmetic operation completes this cycle |
| op_cause | input | 5 | Exceptions raised by that operation |
| cmp_valid | input | 1 | A compare result is delivered this cycle |
| cmp_sel | input | 3 | Condition-code selector |
| cmp_result | input | 1 | Compare outcome |
| round_mode | output | 2 | Rounding mode field |
| flush_denorm | output | 1 | Flush-to-zero control |
| cond_codes | output | 8 | Condition codes 0 to 7 |
| wb_block | output | 1 | Suppress this operation's result write |
| trap_req | output | 1 | Enabled exception pending in stored word |

## Verification
The bench targets the five-bit offset between the enable field and the cause field. A design that aligned them wrongly would trap on the wrong exception or on none. It checks that the sixth cause bit is cleared on every operation while the flags only accumulate; a design that merged causes would leave stale exceptions behind. It also checks the split placement of condition code 0 at bit 23 against codes 1 to 7 at bits 25 to 31, which an off-by-one would corrupt into the flush-denormal bit. Finally it checks that writes to indices other than 31 and operations colliding with a software write leave no trace in the word.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
    localparam int WORD_W     = 32;
    localparam int IDX_W      = 5;
    localparam int EXC_N      = 5;
    localparam int CC_N       = 8;
    localparam int SEL_W      = $clog2(CC_N);
    localparam int CAUSE_W    = EXC_N + 1;
    localparam int RM_LO      = 0;
    localparam int RM_W       = 2;
    localparam int FLAG_LO    = 2;
    localparam int EN_LO      = FLAG_LO + EXC_N;
    localparam int CAUSE_LO   = EN_LO + EXC_N;
    localparam int CC0_POS    = 23;
    localparam int FLUSH_POS  = 24;
    localparam int CC_HI_BASE = 25;
    localparam logic [IDX_W-1:0] STATUS_IDX = 5'd31;

    function automatic int cc_pos(input int n);
        return (n == 0) ? CC0_POS : CC_HI_BASE + n - 1;
    endfunction
endpackage

// File: rtl/fcsr_access.sv
module fcsr_access
    import fcsr_pkg::*;
(
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] rd_data,
    output logic              sw_load
);
    // Only the status index is backed by storage; the revision and all
    // remaining indices read back as zero and swallow writes.
    always_comb begin
        rd_data = (rd_idx == STATUS_IDX) ? word : '0;
        sw_load = wr_en && (wr_idx == STATUS_IDX);
    end
endmodule

// File: rtl/fcsr_exc.sv
module fcsr_exc
    import fcsr_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic              op_valid,
    input  logic [EXC_N-1:0]  op_cause,
    output logic [WORD_W-1:0] word_out,
    output logic              wb_block,
    output logic              trap_pending
);
    logic [EXC_N-1:0] en_f;
    logic [EXC_N-1:0] cause_f;

    always_comb begin
        en_f     = word_in[EN_LO +: EXC_N];
        cause_f  = word_in[CAUSE_LO +: EXC_N];
        word_out = word_in;
        if (op_valid) begin
            // cause is rewritten whole, flags accumulate
            word_out[CAUSE_LO +: CAUSE_W] = {{(CAUSE_W-EXC_N){1'b0}}, op_cause};
            word_out[FLAG_LO +: EXC_N]    = word_in[FLAG_LO +: EXC_N] | op_cause;
        end
        wb_block     = op_valid && ((op_cause & en_f) != '0);
        trap_pending = (cause_f & en_f) != '0;
    end
endmodule

// File: rtl/fcsr_cc.sv
module fcsr_cc
    import fcsr_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic              cmp_valid,
    input  logic [SEL_W-1:0]  cmp_sel,
    input  logic              cmp_result,
    output logic [WORD_W-1:0] word_out,
    output logic [CC_N-1:0]   cc_out
);
    logic [CC_N-1:0]   hit;
    logic [WORD_W-1:0] sel_mask;

    for (genvar g = 0; g < CC_N; g++) begin : g_cc
        assign hit[g]    = cmp_valid && (int'(cmp_sel) == g);
        assign cc_out[g] = word_in[cc_pos(g)];
    end

    always_comb begin
        sel_mask = '0;
        for (int g = 0; g < CC_N; g++) begin
            if (hit[g]) sel_mask[cc_pos(g)] = 1'b1;
        end
        word_out = (word_in & ~sel_mask) | (sel_mask & {WORD_W{cmp_result}});
    end
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
    import fcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              op_valid,
    input  logic [EXC_N-1:0]  op_cause,
    input  logic              cmp_valid,
    input  logic [SEL_W-1:0]  cmp_sel,
    input  logic              cmp_result,
    output logic [RM_W-1:0]   round_mode,
    output logic              flush_denorm,
    output logic [CC_N-1:0]   cond_codes,
    output logic              wb_block,
    output logic              trap_req
);
    logic [WORD_W-1:0] status_q;
    logic [WORD_W-1:0] after_exc;
    logic [WORD_W-1:0] after_cc;
    logic [WORD_W-1:0] status_d;
    logic              sw_load;
    logic              trap_pending;

    fcsr_access u_access (
        .rd_idx  (rd_idx),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .word    (status_q),
        .rd_data (rd_data),
        .sw_load (sw_load)
    );

    fcsr_exc u_exc (
        .word_in      (status_q),
        .op_valid     (op_valid),
        .op_cause     (op_cause),
        .word_out     (after_exc),
        .wb_block     (wb_block),
        .trap_pending (trap_pending)
    );

    fcsr_cc u_cc (
        .word_in    (after_exc),
        .cmp_valid  (cmp_valid),
        .cmp_sel    (cmp_sel),
        .cmp_result (cmp_result),
        .word_out   (after_cc),
        .cc_out     (cond_codes)
    );

    always_comb begin
        status_d = sw_load ? wr_data : after_cc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    always_comb begin
        round_mode   = status_q[RM_LO +: RM_W];
        flush_denorm = status_q[FLUSH_POS];
        trap_req     = trap_pending;
    end
endmodule

// File: rtl/fcsr_unit_chk.sv
module fcsr_unit_chk
    import fcsr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [WORD_W-1:0] rd_data,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [WORD_W-1:0] wr_data,
    input logic              op_valid,
    input logic [EXC_N-1:0]  op_cause,
    input logic              cmp_valid,
    input logic [SEL_W-1:0]  cmp_sel,
    input logic              cmp_result,
    input logic [CC_N-1:0]   cond_codes,
    input logic              wb_block,
    input logic              trap_req,
    input logic [WORD_W-1:0] status_q
);
    logic sw_hit;
    assign sw_hit = wr_en && (wr_idx == STATUS_IDX);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0));

    p_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx != STATUS_IDX) |-> (rd_data == '0));

    p_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sw_hit && !op_valid && !cmp_valid) |=> $stable(status_q));

    p_flags_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_hit |=> (($past(status_q[FLAG_LO +: EXC_N]) & ~status_q[FLAG_LO +: EXC_N]) == '0));

    p_block_needs_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_block |-> op_valid);

    p_enabled_op_traps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sw_hit && ((op_cause & status_q[EN_LO +: EXC_N]) != '0)) |=> trap_req);

    p_cc_written_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !sw_hit) |=> (cond_codes[$past(cmp_sel)] == $past(cmp_result)));

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_hit |=> (status_q == $past(wr_data)));
endmodule

bind fcsr_unit fcsr_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .op_valid   (op_valid),
    .op_cause   (op_cause),
    .cmp_valid  (cmp_valid),
    .cmp_sel    (cmp_sel),
    .cmp_result (cmp_result),
    .cond_codes (cond_codes),
    .wb_block   (wb_block),
    .trap_req   (trap_req),
    .status_q   (status_q)
);

// File: tb/fcsr_unit_bench.sv
module fcsr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_cause = '0;
    logic        cmp_valid = 1'b0;
    logic [2:0]  cmp_sel = '0;
    logic        cmp_result = 1'b0;
    logic [1:0]  round_mode;
    logic        flush_denorm;
    logic [7:0]  cond_codes;
    logic        wb_block;
    logic        trap_req;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic [31:0] model = '0;

    always #10 clk = ~clk;

    fcsr_unit u_fcsr_unit (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .op_valid(op_valid), .op_cause(op_cause),
        .cmp_valid(cmp_valid), .cmp_sel(cmp_sel), .cmp_result(cmp_result),
        .round_mode(round_mode), .flush_denorm(flush_denorm),
        .cond_codes(cond_codes), .wb_block(wb_block), .trap_req(trap_req)
    );

    function automatic logic [31:0] next_word(
        input logic [31:0] s, input logic we, input logic [4:0] wi, input logic [31:0] wd,
        input logic ov, input logic [4:0] oc, input logic cv, input logic [2:0] cs, input logic cr);
        logic [31:0] r;
        int pos;
        if (we && wi == 5'd31) return wd;       // R10 write wins
        r = s;
        if (ov) begin                           // R5
            r[17:12] = {1'b0, oc};
            r[6:2]   = r[6:2] | oc;
        end
        if (cv) begin                           // R9
            pos = (cs == 3'd0) ? 23 : 24 + int'(cs);
            r[pos] = cr;
        end
        return r;
    endfunction

    function automatic logic [7:0] cc_of(input logic [31:0] s);
        return {s[31:25], s[23]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                        input logic ov, input logic [4:0] oc,
                        input logic cv, input logic [2:0] cs, input logic cr,
                        input logic [4:0] ri);
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_data = wd;
        op_valid = ov; op_cause = oc;
        cmp_valid = cv; cmp_sel = cs; cmp_result = cr;
        rd_idx = ri;
        #2;
        chk("R2 read data", rd_data, (ri == 5'd31) ? model : 32'h0);
        chk("R6 writeback block", {31'h0, wb_block},
            {31'h0, ov && ((oc & model[11:7]) != 5'h0)});
        chk("R7 trap level", {31'h0, trap_req}, {31'h0, (model[16:12] & model[11:7]) != 5'h0});
        chk("R4 rounding mode", {30'h0, round_mode}, {30'h0, model[1:0]});
        chk("R4 flush control", {31'h0, flush_denorm}, {31'h0, model[24]});
        chk("R9 condition codes", {24'h0, cond_codes}, {24'h0, cc_of(model)});
        model = next_word(model, we, wi, wd, ov, oc, cv, cs, cr);
    endtask

    task automatic idle_read();
        step(1'b0, 5'd0, 32'h0, 1'b0, 5'h0, 1'b0, 3'd0, 1'b0, 5'd31);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        // R1: load junk, then reset
        rst_n = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd31; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_en = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; rd_idx = 5'd31;
        #2;
        chk("R1 reset word", rd_data, 32'h0);
        chk("R1 reset outputs", {19'h0, round_mode, flush_denorm, cond_codes, wb_block, trap_req}, 32'h0);
        model = '0;

        // R3: write to revision index and another index is dropped
        step(1'b1, 5'd0, 32'hFFFF_FFFF, 1'b0, 5'h0, 1'b0, 3'd0, 1'b0, 5'd0);
        step(1'b1, 5'd7, 32'hFFFF_FFFF, 1'b0, 5'h0, 1'b0, 3'd0, 1'b0, 5'd31);
        #1 chk("R3 non-status write ignored", rd_data, 32'h0);

        // R4: each rounding code plus flush
        for (int m = 0; m < 4; m++) begin
            step(1'b1, 5'd31, 32'h0100_0000 | m, 1'b0, 5'h0, 1'b0, 3'd0, 1'b0, 5'd31);
        end
        idle_read();

        // R8: software write with enabled invalid pending
        step(1'b1, 5'd31, 32'h0001_0800, 1'b0, 5'h0, 1'b0, 3'd0, 1'b0, 5'd31);
        idle_read();
        chk("R8 software write trap", {31'h0, trap_req}, 32'h1);
        // unimplemented cause bit 17 never traps
        step(1'b1, 5'd31, 32'h0002_0F80, 1'b0, 5'h0, 1'b0, 3'd0, 1'b0, 5'd31);
        idle_read();
        chk("R7 bit17 no trap", {31'h0, trap_req}, 32'h0);

        // R5/R6: enable divide-by-zero only, raise each cause
        step(1'b1, 5'd31, 32'h0000_0400, 1'b0, 5'h0, 1'b0, 3'd0, 1'b0, 5'd31);
        step(1'b0, 5'd0, 32'h0, 1'b1, 5'h08, 1'b0, 3'd0, 1'b0, 5'd31);
        step(1'b0, 5'd0, 32'h0, 1'b1, 5'h01, 1'b0, 3'd0, 1'b0, 5'd31);
        idle_read();
        chk("R5 cause replaced flags kept", rd_data, 32'h0000_1000 | 32'h0000_0400 | 32'h0000_0024);

        // R9: code 0 and code 7 positions
        step(1'b0, 5'd0, 32'h0, 1'b0, 5'h0, 1'b1, 3'd0, 1'b1, 5'd31);
        step(1'b0, 5'd0, 32'h0, 1'b0, 5'h0, 1'b1, 3'd7, 1'b1, 5'd31);
        idle_read();
        chk("R9 code bits 23 and 31", rd_data & 32'h8180_0000, 32'h8080_0000);

        // R10: write collides with op and compare
        step(1'b1, 5'd31, 32'h0000_0003, 1'b1, 5'h1F, 1'b1, 3'd1, 1'b1, 5'd31);
        idle_read();
        chk("R10 write wins", rd_data, 32'h0000_0003);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic we;
            logic [4:0] wi;
            we = ($urandom % 8) == 0;
            wi = ($urandom % 2) ? 5'd31 : 5'($urandom);
            step(we, wi, $urandom, ($urandom % 2) == 1, 5'($urandom),
                 ($urandom % 2) == 1, 3'($urandom), 1'($urandom),
                 ($urandom % 4 == 0) ? 5'($urandom) : 5'd31);
        end
        idle_read();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule